// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block sits on the controller side of an SDRAM interface and keeps the array refreshed. An internal interval timer marks each point at which a refresh falls due. Each such point adds one to a small backlog counter. The block raises a request to the main command arbiter. Once the arbiter grants the command bus, the block closes every bank with a precharge-all, waits out the row precharge time, and issues an auto refresh. It then drives NOP until the refresh cycle time has elapsed. If the grant is still held at that point and refreshes are still owed, it issues the next refresh at once, with no further precharge.

The same sequence also puts the memory into self refresh. The block precharges first, then issues the refresh encoding with the clock enable low. It holds the clock enable low for as long as the self-refresh request stays high. When the request drops, it raises the clock enable and keeps the bus busy for one refresh cycle time. The clock period and every timing value are parameters in nanoseconds. Each value is turned into a clock count by rounding up, with a floor of two cycles.

Top module: `sdram_refresh_sched`

## Requirements
- R1: During and right after reset the pins carry NOP (chip select low, RAS, CAS and WE high, A10 low), the clock enable is high, and the busy, request and backlog outputs are all zero.
- R2: With no grant, the backlog rises by one every ceil(TREFI_NS/CLK_NS) cycles, counted from reset release.
- R3: The backlog saturates at BACKLOG_MAX; a due point while it is full leaves it unchanged.
- R4: A sequence starts only from idle, on a cycle where the grant is high and either the backlog is non-zero or self refresh is requested. Its first command is precharge-all: chip select low, RAS low, CAS high, WE low, A10 high.
- R5: Exactly max(ceil(TRP_NS/CLK_NS),2) cycles separate the precharge-all from the refresh command that follows (chip select, RAS and CAS low, WE high, clock enable high), with NOP in between.
- R6: After a refresh, NOP is driven and no other command appears for max(ceil(TRFC_NS/CLK_NS),2) cycles. A further refresh follows at exactly that distance if the grant is still high and the backlog is non-zero, provided self refresh is not requested. Otherwise the block returns to idle.
- R7: Each refresh command takes one from the backlog; a due point in the same cycle cancels it out.
- R8: Busy is high in every cycle from the precharge-all until the block is back in idle, and in no idle cycle.
- R9: Self-refresh entry is the refresh encoding with the clock enable low, placed exactly the precharge gap after the precharge-all. The clock enable stays low while the request is held. The backlog is cleared on entry, and due points are ignored until the block is idle again.
- R10: After the self-refresh request drops, the clock enable returns high. Busy then stays high, with NOP on the pins, for the refresh cycle gap, counted from the first cycle with the clock enable high.
- R11: When self refresh is requested at the moment of grant, it takes priority over an owed auto refresh, and no auto refresh is issued in that sequence.
- R12: The request output is high exactly when the block is idle and either the backlog is non-zero or self refresh is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Arbiter hands the command bus to this block |
| selfref_req | input | 1 | Enter and hold self refresh while high |
| ref_req | output | 1 | Block wants the command bus |
| ref_busy | output | 1 | Block owns the command bus |
| ref_backlog | output | $clog2(BACKLOG_MAX+1) | Number of refreshes owed |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cke | output | 1 | Clock enable |
| mem_a10 | output | 1 | Address bit 10, all-bank select for precharge |

## Verification
The hardest conditions to reach are a full backlog that receives another due point, and a drain in which a due point lands while refreshes are being chained. Both need the grant held back for many intervals and then held high across several refresh cycles. The bench withholds the grant for more than BACKLOG_MAX intervals, then grants and keeps the grant high. A behavioural model follows every cycle, so a due point at any phase of the drain is checked. Self refresh is held for longer than one interval so that an ignored due point shows at the backlog port.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus released
    ST_PRE,    // precharge-all on pins
    ST_WRP,    // precharge recovery
    ST_REF,    // auto refresh on pins
    ST_WRFC,   // refresh recovery
    ST_SRE,    // self refresh entry on pins
    ST_SR,     // in self refresh, clock enable low
    ST_SRX     // clock enable back high, recovery
  } seq_state_t;

  // order: cs_n, ras_n, cas_n, we_n, cke, a10
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic cke;
    logic a10;
  } pin_bundle_t;

  localparam pin_bundle_t PINS_NOP     = 6'b011110;
  localparam pin_bundle_t PINS_PRE_ALL = 6'b001011;
  localparam pin_bundle_t PINS_AREF    = 6'b000110;
  localparam pin_bundle_t PINS_SR_IN   = 6'b000100;
  localparam pin_bundle_t PINS_SR_HOLD = 6'b011100;

  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int gap_cycles(input int ns, input int clk_ns);
    int c;
    c = ns_to_cycles(ns, clk_ns);
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/sdram_refi_timer.sv
module sdram_refi_timer #(
  parameter int PERIOD_CYC = 975
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (PERIOD_CYC <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      localparam int TW = $clog2(PERIOD_CYC);
      logic [TW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == TW'(PERIOD_CYC - 1));

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = wrap;
    end
  endgenerate

endmodule

// File: rtl/sdram_ref_backlog.sv
module sdram_ref_backlog #(
  parameter int MAX = 8,
  parameter int PW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold,
  input  logic          take,
  input  logic          flush,
  output logic [PW-1:0] count,
  output logic          nonzero
);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          add, sub, upd;

  assign add = tick && !hold;
  assign sub = take && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (flush) begin
      cnt_d = '0;
      upd   = 1'b1;
    end else if (add && !sub) begin
      if (cnt_q != PW'(MAX)) begin
        cnt_d = cnt_q + 1'b1;
        upd   = 1'b1;
      end
    end else if (sub && !add) begin
      cnt_d = cnt_q - 1'b1;
      upd   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign nonzero = (cnt_q != '0);

endmodule

// File: rtl/sdram_ref_seq.sv
module sdram_ref_seq
  import sdram_ref_pkg::*;
#(
  parameter int RP_GAP  = 2,
  parameter int RFC_GAP = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        grant,
  input  logic        sr_req,
  input  logic        owed,
  output seq_state_t  state,
  output pin_bundle_t pins
);

  localparam int GMAX = (RFC_GAP > RP_GAP) ? RFC_GAP : RP_GAP;
  localparam int CW   = $clog2(GMAX + 1);

  seq_state_t  state_q, state_d;
  logic [CW-1:0] wait_q, wait_d;
  logic        srm_q, srm_d;
  pin_bundle_t pins_q, pins_d;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    srm_d   = srm_q;
    case (state_q)
      ST_IDLE: begin
        if (grant && (sr_req || owed)) begin
          state_d = ST_PRE;
          srm_d   = sr_req;
        end
      end
      ST_PRE: begin
        state_d = ST_WRP;
        wait_d  = CW'(RP_GAP - 2);
      end
      ST_WRP: begin
        if (wait_q == '0) state_d = srm_q ? ST_SRE : ST_REF;
        else              wait_d  = wait_q - 1'b1;
      end
      ST_REF: begin
        state_d = ST_WRFC;
        wait_d  = CW'(RFC_GAP - 2);
      end
      ST_WRFC: begin
        if (wait_q == '0) state_d = (grant && owed && !sr_req) ? ST_REF : ST_IDLE;
        else              wait_d  = wait_q - 1'b1;
      end
      ST_SRE: state_d = ST_SR;
      ST_SR: begin
        if (!sr_req) begin
          state_d = ST_SRX;
          wait_d  = CW'(RFC_GAP - 1);
        end
      end
      ST_SRX: begin
        if (wait_q == '0) state_d = ST_IDLE;
        else              wait_d  = wait_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pins are registered from the next state so they line up with state_q
  always_comb begin
    case (state_d)
      ST_PRE:  pins_d = PINS_PRE_ALL;
      ST_REF:  pins_d = PINS_AREF;
      ST_SRE:  pins_d = PINS_SR_IN;
      ST_SR:   pins_d = PINS_SR_HOLD;
      default: pins_d = PINS_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      srm_q   <= 1'b0;
      pins_q  <= PINS_NOP;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      srm_q   <= srm_d;
      pins_q  <= pins_d;
    end
  end

  assign state = state_q;
  assign pins  = pins_q;

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_ref_pkg::*;
#(
  parameter int CLK_NS      = 8,
  parameter int TRP_NS      = 15,
  parameter int TRFC_NS     = 60,
  parameter int TREFI_NS    = 7800,
  parameter int BACKLOG_MAX = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ref_grant,
  input  logic                               selfref_req,
  output logic                               ref_req,
  output logic                               ref_busy,
  output logic [$clog2(BACKLOG_MAX+1)-1:0]   ref_backlog,
  output logic                               mem_cs_n,
  output logic                               mem_ras_n,
  output logic                               mem_cas_n,
  output logic                               mem_we_n,
  output logic                               mem_cke,
  output logic                               mem_a10
);

  localparam int PW      = $clog2(BACKLOG_MAX + 1);
  localparam int RP_GAP  = gap_cycles(TRP_NS, CLK_NS);
  localparam int RFC_GAP = gap_cycles(TRFC_NS, CLK_NS);
  localparam int REFI    = ns_to_cycles(TREFI_NS, CLK_NS);

  logic        due;
  logic        owed;
  seq_state_t  st;
  pin_bundle_t pins;

  sdram_refi_timer #(.PERIOD_CYC(REFI)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (due)
  );

  sdram_ref_backlog #(.MAX(BACKLOG_MAX), .PW(PW)) u_backlog (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (due),
    .hold    ((st == ST_SR) || (st == ST_SRX)),
    .take    (st == ST_REF),
    .flush   (st == ST_SRE),
    .count   (ref_backlog),
    .nonzero (owed)
  );

  sdram_ref_seq #(.RP_GAP(RP_GAP), .RFC_GAP(RFC_GAP)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .grant  (ref_grant),
    .sr_req (selfref_req),
    .owed   (owed),
    .state  (st),
    .pins   (pins)
  );

  assign ref_busy  = (st != ST_IDLE);
  assign ref_req   = (st == ST_IDLE) && (owed || selfref_req);
  assign mem_cs_n  = pins.cs_n;
  assign mem_ras_n = pins.ras_n;
  assign mem_cas_n = pins.cas_n;
  assign mem_we_n  = pins.we_n;
  assign mem_cke   = pins.cke;
  assign mem_a10   = pins.a10;

endmodule

// File: rtl/sdram_refresh_chk.sv
module sdram_refresh_chk
  import sdram_ref_pkg::*;
#(
  parameter int CLK_NS      = 8,
  parameter int TRFC_NS     = 60,
  parameter int BACKLOG_MAX = 8,
  parameter int PW          = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_req,
  input logic          ref_busy,
  input logic [PW-1:0] ref_backlog,
  input logic          mem_cs_n,
  input logic          mem_ras_n,
  input logic          mem_cas_n,
  input logic          mem_we_n,
  input logic          mem_cke,
  input logic          mem_a10
);

  localparam int RFC_GAP = gap_cycles(TRFC_NS, CLK_NS);
  localparam int SW      = $clog2(RFC_GAP + 1);

  logic is_pre, is_ref_enc, is_nop, is_cmd;
  logic [SW-1:0] since_ref;

  assign is_pre     = !mem_cs_n && !mem_ras_n && mem_cas_n && !mem_we_n;
  assign is_ref_enc = !mem_cs_n && !mem_ras_n && !mem_cas_n && mem_we_n;
  assign is_nop     = !mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n;
  assign is_cmd     = !mem_cs_n && !is_nop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_ref <= SW'(RFC_GAP);
    else if (is_ref_enc)                 since_ref <= SW'(1);
    else if (since_ref != SW'(RFC_GAP))  since_ref <= since_ref + 1'b1;
  end

  // R4
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> mem_a10);

  // R5
  pre_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> is_nop);

  // R6
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since_ref == SW'(RFC_GAP)));

  // R3
  backlog_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_backlog <= PW'(BACKLOG_MAX));

  // R8
  cmd_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> ref_busy);

  // R9
  sr_entry_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cke) |-> is_ref_enc);

  // R10
  sr_exit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> (ref_busy && is_nop));

  // R12
  req_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !ref_busy);

endmodule

bind sdram_refresh_sched sdram_refresh_chk #(
  .CLK_NS      (CLK_NS),
  .TRFC_NS     (TRFC_NS),
  .BACKLOG_MAX (BACKLOG_MAX),
  .PW          ($clog2(BACKLOG_MAX + 1))
) u_refresh_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_req     (ref_req),
  .ref_busy    (ref_busy),
  .ref_backlog (ref_backlog),
  .mem_cs_n    (mem_cs_n),
  .mem_ras_n   (mem_ras_n),
  .mem_cas_n   (mem_cas_n),
  .mem_we_n    (mem_we_n),
  .mem_cke     (mem_cke),
  .mem_a10     (mem_a10)
);

// File: tb/test_sdram_refresh_sched.sv
`timescale 1ns/1ps
module test_sdram_refresh_sched;

  localparam int CLK_NS = 8, TRP_NS = 15, TRFC_NS = 60, TREFI_NS = 7800, BMAX = 8;
  localparam int PW     = $clog2(BMAX + 1);
  localparam int E_RP   = ((TRP_NS + CLK_NS - 1) / CLK_NS < 2) ? 2 : (TRP_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_RFC  = ((TRFC_NS + CLK_NS - 1) / CLK_NS < 2) ? 2 : (TRFC_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_REFI = (TREFI_NS + CLK_NS - 1) / CLK_NS;

  localparam int P_IDLE = 0, P_PRE = 1, P_WRP = 2, P_REF = 3, P_WRFC = 4,
                 P_SRE = 5, P_SR = 6, P_SRX = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic g, s;
  logic req, busy, cs_n, ras_n, cas_n, we_n, cke, a10;
  logic [PW-1:0] backlog;

  always #4 clk = ~clk;

  sdram_refresh_sched #(
    .CLK_NS(CLK_NS), .TRP_NS(TRP_NS), .TRFC_NS(TRFC_NS),
    .TREFI_NS(TREFI_NS), .BACKLOG_MAX(BMAX)
  ) i_sdram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_grant(g), .selfref_req(s),
    .ref_req(req), .ref_busy(busy), .ref_backlog(backlog),
    .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n), .mem_we_n(we_n),
    .mem_cke(cke), .mem_a10(a10)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int ph, wt, pd, tc;
  bit srm;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = P_IDLE; wt = 0; pd = 0; tc = 0; srm = 0;
    end else begin
      int np;
      bit tk;
      tk = (tc == E_REFI - 1) && ph != P_SR && ph != P_SRX;
      tc = (tc == E_REFI - 1) ? 0 : tc + 1;
      np = pd;
      if (ph == P_SRE)              np = 0;
      else if (tk && ph != P_REF)   np = (pd < BMAX) ? pd + 1 : BMAX;
      else if (!tk && ph == P_REF)  np = pd - 1;
      case (ph)
        P_IDLE: if (g && (s || pd > 0)) begin ph = P_PRE; srm = s; end
        P_PRE:  begin ph = P_WRP; wt = E_RP - 1; end
        P_WRP:  if (wt == 1) ph = srm ? P_SRE : P_REF; else wt--;
        P_REF:  begin ph = P_WRFC; wt = E_RFC - 1; end
        P_WRFC: if (wt == 1) ph = (g && pd > 0 && !s) ? P_REF : P_IDLE; else wt--;
        P_SRE:  ph = P_SR;
        P_SR:   if (!s) begin ph = P_SRX; wt = E_RFC; end
        P_SRX:  if (wt == 1) ph = P_IDLE; else wt--;
        default: ph = P_IDLE;
      endcase
      pd = np;
    end
  end

  function automatic logic [5:0] exp_pins(input int p);
    case (p)
      P_PRE:   return 6'b001011;
      P_REF:   return 6'b000110;
      P_SRE:   return 6'b000100;
      P_SR:    return 6'b011100;
      default: return 6'b011110;
    endcase
  endfunction

  // per-cycle comparison plus spacing monitor
  int last_pre = -1000, last_ref = -1000, last_kind = 0, refs_seen = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      logic [5:0] pv;
      pv = {cs_n, ras_n, cas_n, we_n, cke, a10};
      chk(pv == exp_pins(ph), "R4 pins vs model", pv, exp_pins(ph));
      chk(busy == (ph != P_IDLE), "R8 busy", busy, ph != P_IDLE);
      chk(backlog == pd, "R2 backlog", backlog, pd);
      chk(req == (ph == P_IDLE && (pd > 0 || s)), "R12 request", req, ph == P_IDLE && (pd > 0 || s));
      if (pv == 6'b001011) begin last_pre = cyc; last_kind = 1; end
      if (pv == 6'b000110) begin
        refs_seen++;
        if (last_kind == 1) chk(cyc - last_pre == E_RP, "R5 pre to ref gap", cyc - last_pre, E_RP);
        else                chk(cyc - last_ref == E_RFC, "R6 ref to ref gap", cyc - last_ref, E_RFC);
        last_ref = cyc; last_kind = 2;
      end
      if (pv == 6'b000100) begin
        chk(last_kind == 1 && cyc - last_pre == E_RP, "R9 pre to entry gap", cyc - last_pre, E_RP);
        last_kind = 3;
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 60000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, r0;
    rst_n = 1'b0; g = 1'b0; s = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cs_n, ras_n, cas_n, we_n, cke, a10} == 6'b011110, "R1 pins", {cs_n, ras_n, cas_n, we_n, cke, a10}, 6'b011110);
    chk(!busy && !req && backlog == 0, "R1 flags", {busy, req, backlog}, 0);
    rst_n = 1'b1;

    // R2 first due point
    n = 0;
    do begin @(negedge clk); n++; end while (backlog == 0 && n < 3000);
    chk(n == E_REFI, "R2 interval", n, E_REFI);
    chk(req == 1, "R12 req raised", req, 1);

    // R3 saturation, R4 no grant means no sequence
    repeat (BMAX * E_REFI) @(negedge clk);
    chk(backlog == BMAX, "R3 full", backlog, BMAX);
    repeat (E_REFI) @(negedge clk);
    chk(backlog == BMAX, "R3 held at cap", backlog, BMAX);
    chk(busy == 0, "R4 idle without grant", busy, 0);

    // R6/R7 drain with grant held
    r0 = refs_seen;
    g = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while ((backlog != 0 || busy) && n < 2000);
    g = 1'b0;
    chk(backlog == 0, "R7 drained", backlog, 0);
    chk(refs_seen - r0 >= BMAX, "R7 refresh count", refs_seen - r0, BMAX);

    // R4 grant with nothing owed
    g = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 || backlog != 0, "R4 no work no sequence", busy, 0);
    g = 1'b0;

    // R9/R11 self refresh with a refresh owed
    n = 0;
    do begin @(negedge clk); n++; end while (backlog == 0 && n < 3000);
    r0 = refs_seen;
    s = 1'b1; g = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (cke == 1 && n < 100);
    g = 1'b0;
    chk(cke == 0, "R9 entered", cke, 0);
    chk(refs_seen == r0, "R11 no auto refresh", refs_seen - r0, 0);
    @(negedge clk);
    chk(backlog == 0, "R9 backlog cleared", backlog, 0);
    repeat (E_REFI + 200) @(negedge clk);
    chk(cke == 0 && backlog == 0, "R9 held, due point ignored", {cke, backlog}, 0);

    // R10 exit
    s = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (cke == 0 && n < 10);
    n = 0;
    while (busy && n < 100) begin
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R10 nop during exit", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      @(negedge clk); n++;
    end
    chk(n == E_RFC, "R10 exit recovery", n, E_RFC);

    // R6 single grant pulse, returns idle after one refresh
    n = 0;
    do begin @(negedge clk); n++; end while (backlog == 0 && n < 3000);
    r0 = refs_seen;
    g = 1'b1; @(negedge clk); g = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 100);
    chk(refs_seen - r0 == 1, "R6 one refresh per pulse", refs_seen - r0, 1);
    chk(busy == 0, "R6 back to idle", busy, 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule